// File: doc/BRIEF.md
# Hash-Based Receive Queue Distribution Stage

This block turns a received frame's parsed header fields into a destination queue ID. A per-scheme configuration chooses which known header fields make up a hash key. For each chosen IPv4 address or L4 port that the frame lacks, a configured default takes its place. The key is hashed to 64 bits. A shift picks 24 of those bits, a mask keeps the part that falls inside a power-of-two queue range, and that part is merged with a 24-bit queue base.

The stage is fully pipelined and accepts one frame per clock. Each frame's configuration is sampled together with the frame, so software may change the scheme while earlier frames are still in flight. An optional symmetric mode orders each source/destination pair before hashing. Both directions of a flow then land on the same queue. Header parsing and scheme matching happen upstream.

Top module: `hqd_dist`

## Requirements
- R1: A frame presented while `scm_en_i` is 0 produces no `qid_valid_o` strobe.
- R2: A frame accepted at clock edge E (with `frm_valid_i` and `scm_en_i` high) raises `qid_valid_o` for one cycle after edge E+2, and no earlier. Frames on consecutive cycles give strobes on consecutive cycles. After reset, `qid_valid_o` and `qid_o` are 0.
- R3: `scm_fld_sel_i` bit 4 selects IP source, bit 3 IP destination, bit 2 IPsec SPI (32 bits each), bit 1 L4 source port and bit 0 L4 destination port (16 bits each). The selected fields are concatenated from bit 4 down to bit 0. The result is hashed with CRC-64 using polynomial 0x42F0E1EBA9EA3693, initial value 0, each field fed MSB first, no reflection and no final inversion.
- R4: When `frm_ip_ok_i` is 0, both IP fields are replaced by a default chosen by `scm_ip_dsel_i`: code 2 gives `scm_dflt0_i`, code 3 gives `scm_dflt1_i`, and codes 0 and 1 give zero.
- R5: When `frm_l4_ok_i` is 0, both port fields are replaced by the low 16 bits of a default chosen by `scm_l4_dsel_i`, using the same codes as R4.
- R6: The 24 hash bits used are bits [S+23:S] of the 64-bit hash, where S is `scm_shift_i` (0 to 63), with zeros filled in above bit 63.
- R7: `qid_o` equals `scm_qbase_i` OR (the 24 selected hash bits AND `scm_qmask_i`). The mask is the queue count minus one.
- R8: When `scm_sym_i` is 1, each IP pair and each port pair is ordered smaller value first, after default substitution. Swapping source and destination then yields the same `qid_o`.
- R9: When no field is selected, the hash is 0 and `qid_o` equals `scm_qbase_i`.
- R10: All configuration inputs are sampled at the edge that accepts the frame. Changes afterwards do not affect that frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scm_en_i | input | 1 | Scheme enable |
| scm_fld_sel_i | input | 5 | Known-field selection mask |
| scm_ip_dsel_i | input | 2 | Default code for absent IP addresses |
| scm_l4_dsel_i | input | 2 | Default code for absent L4 ports |
| scm_dflt0_i | input | 32 | Default value register 0 |
| scm_dflt1_i | input | 32 | Default value register 1 |
| scm_sym_i | input | 1 | Symmetric hash request |
| scm_shift_i | input | 6 | Right shift applied to the 64-bit hash |
| scm_qmask_i | input | 24 | Queue count minus one |
| scm_qbase_i | input | 24 | Queue base, aligned to queue count |
| frm_valid_i | input | 1 | Frame descriptor strobe |
| frm_ip_ok_i | input | 1 | Frame carries IPv4 addresses |
| frm_l4_ok_i | input | 1 | Frame carries L4 ports |
| frm_ip_src_i | input | 32 | IP source address |
| frm_ip_dst_i | input | 32 | IP destination address |
| frm_spi_i | input | 32 | IPsec SPI |
| frm_l4_src_i | input | 16 | L4 source port |
| frm_l4_dst_i | input | 16 | L4 destination port |
| qid_valid_o | output | 1 | Queue ID strobe |
| qid_o | output | 24 | Destination queue ID |

## Verification
The case hardest to reach from the ports is the one where several in-flight frames each carry a different configuration. To reach it, a burst of back-to-back frames is driven with the scheme changed on every cycle. The configuration is then scrambled while the last frames are still in the pipeline, and each strobe is checked against the configuration of its own frame. A sweep over all 32 field masks is crossed with every absent-field combination, the symmetric flag, rotating default codes, shifts and masks. This exercises the variable-length key and the substitution paths. A separate pass runs every shift from 0 to 63 on a single key.

// File: rtl/hqd_pkg.sv
package hqd_pkg;
  localparam int unsigned NUM_FLD = 5;
  localparam int unsigned FLD_W   = 32;
  localparam int unsigned HASH_W  = 64;
  localparam logic [HASH_W-1:0] CRC_POLY = 64'h42F0_E1EB_A9EA_3693;

  // field index = key position, 0 is fed first
  typedef enum logic [2:0] {
    F_IP_SRC = 3'd0,
    F_IP_DST = 3'd1,
    F_SPI    = 3'd2,
    F_L4_SRC = 3'd3,
    F_L4_DST = 3'd4
  } fld_e;

  typedef enum logic [1:0] {
    DS_NONE_A = 2'd0,
    DS_NONE_B = 2'd1,
    DS_REG0   = 2'd2,
    DS_REG1   = 2'd3
  } dsel_e;

  function automatic int unsigned fld_bits(input int unsigned idx);
    return (idx >= int'(F_L4_SRC)) ? 16 : 32;
  endfunction

  function automatic logic [HASH_W-1:0] crc_feed(input logic [HASH_W-1:0] st,
                                                 input logic [FLD_W-1:0]  d,
                                                 input int unsigned       nbits);
    logic [HASH_W-1:0] s;
    logic fb;
    s = st;
    for (int j = FLD_W - 1; j >= 0; j--) begin
      if (j < int'(nbits)) begin
        fb = s[HASH_W-1] ^ d[j];
        s  = {s[HASH_W-2:0], 1'b0};
        if (fb) s = s ^ CRC_POLY;
      end
    end
    return s;
  endfunction

  function automatic logic [FLD_W-1:0] dflt_pick(input dsel_e c,
                                                 input logic [FLD_W-1:0] d0,
                                                 input logic [FLD_W-1:0] d1);
    case (c)
      DS_REG0: return d0;
      DS_REG1: return d1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/hqd_key_build.sv
module hqd_key_build
  import hqd_pkg::*;
#(
  parameter int unsigned QW = 24,
  parameter int unsigned SW = 6,
  parameter int unsigned PW = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [NUM_FLD-1:0]            fld_sel_i,
  input  logic [1:0]                    ip_dsel_i,
  input  logic [1:0]                    l4_dsel_i,
  input  logic [FLD_W-1:0]              dflt0_i,
  input  logic [FLD_W-1:0]              dflt1_i,
  input  logic                          sym_i,
  input  logic [SW-1:0]                 shift_i,
  input  logic [QW-1:0]                 qmask_i,
  input  logic [QW-1:0]                 qbase_i,
  input  logic                          frm_valid_i,
  input  logic                          ip_ok_i,
  input  logic                          l4_ok_i,
  input  logic [FLD_W-1:0]              ip_src_i,
  input  logic [FLD_W-1:0]              ip_dst_i,
  input  logic [FLD_W-1:0]              spi_i,
  input  logic [PW-1:0]                 l4_src_i,
  input  logic [PW-1:0]                 l4_dst_i,
  output logic                          key_valid_o,
  output logic [NUM_FLD-1:0]            key_sel_o,
  output logic [NUM_FLD-1:0][FLD_W-1:0] key_fld_o,
  output logic [SW-1:0]                 key_shift_o,
  output logic [QW-1:0]                 key_qmask_o,
  output logic [QW-1:0]                 key_qbase_o
);
  localparam int unsigned PAD = FLD_W - PW;

  logic [FLD_W-1:0] ip_dv, ip_a, ip_b;
  logic [PW-1:0]    pt_dv, pt_a, pt_b;
  logic [NUM_FLD-1:0]            sel_d;
  logic [NUM_FLD-1:0][FLD_W-1:0] fld_d;
  logic sym_q;

  // port bit (NUM_FLD-1) is key position 0
  for (genvar i = 0; i < NUM_FLD; i++) begin : g_sel
    assign sel_d[i] = fld_sel_i[NUM_FLD-1-i];
  end

  always_comb begin
    ip_dv = dflt_pick(dsel_e'(ip_dsel_i), dflt0_i, dflt1_i);
    pt_dv = PW'(dflt_pick(dsel_e'(l4_dsel_i), dflt0_i, dflt1_i));
    ip_a  = ip_ok_i ? ip_src_i : ip_dv;
    ip_b  = ip_ok_i ? ip_dst_i : ip_dv;
    pt_a  = l4_ok_i ? l4_src_i : pt_dv;
    pt_b  = l4_ok_i ? l4_dst_i : pt_dv;
    if (sym_i && (ip_a > ip_b)) begin
      ip_a = ip_b;
      ip_b = ip_ok_i ? ip_src_i : ip_dv;
    end
    if (sym_i && (pt_a > pt_b)) begin
      pt_a = pt_b;
      pt_b = l4_ok_i ? l4_src_i : pt_dv;
    end
    fld_d           = '0;
    fld_d[F_IP_SRC] = ip_a;
    fld_d[F_IP_DST] = ip_b;
    fld_d[F_SPI]    = spi_i;
    fld_d[F_L4_SRC] = {{PAD{1'b0}}, pt_a};
    fld_d[F_L4_DST] = {{PAD{1'b0}}, pt_b};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_valid_o <= 1'b0;
      key_sel_o   <= '0;
      key_fld_o   <= '0;
      key_shift_o <= '0;
      key_qmask_o <= '0;
      key_qbase_o <= '0;
      sym_q       <= 1'b0;
    end else begin
      key_valid_o <= frm_valid_i & en_i;
      if (frm_valid_i) begin
        key_sel_o   <= sel_d;
        key_fld_o   <= fld_d;
        key_shift_o <= shift_i;
        key_qmask_o <= qmask_i;
        key_qbase_o <= qbase_i;
        sym_q       <= sym_i;
      end
    end
  end

  AST_SYM_ORDERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o && sym_q |->
      (key_fld_o[F_IP_SRC] <= key_fld_o[F_IP_DST]) &&
      (key_fld_o[F_L4_SRC] <= key_fld_o[F_L4_DST])); // R8
endmodule

// File: rtl/hqd_crc_stage.sv
module hqd_crc_stage
  import hqd_pkg::*;
#(
  parameter int unsigned QW = 24,
  parameter int unsigned SW = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [NUM_FLD-1:0]            sel_i,
  input  logic [NUM_FLD-1:0][FLD_W-1:0] fld_i,
  input  logic [SW-1:0]                 shift_i,
  input  logic [QW-1:0]                 qmask_i,
  input  logic [QW-1:0]                 qbase_i,
  output logic                          valid_o,
  output logic [HASH_W-1:0]             hash_o,
  output logic [SW-1:0]                 shift_o,
  output logic [QW-1:0]                 qmask_o,
  output logic [QW-1:0]                 qbase_o
);
  logic [NUM_FLD:0][HASH_W-1:0] chain;

  assign chain[0] = '0;
  // unselected fields pass the running state through
  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    assign chain[i+1] = sel_i[i] ? crc_feed(chain[i], fld_i[i], fld_bits(i))
                                 : chain[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hash_o  <= '0;
      shift_o <= '0;
      qmask_o <= '0;
      qbase_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hash_o  <= chain[NUM_FLD];
        shift_o <= shift_i;
        qmask_o <= qmask_i;
        qbase_o <= qbase_i;
      end
    end
  end

  AST_EMPTY_KEY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ($past(sel_i) == '0) |-> hash_o == '0); // R9
endmodule

// File: rtl/hqd_qsel.sv
module hqd_qsel
  import hqd_pkg::*;
#(
  parameter int unsigned QW = 24,
  parameter int unsigned SW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [HASH_W-1:0] hash_i,
  input  logic [SW-1:0]     shift_i,
  input  logic [QW-1:0]     qmask_i,
  input  logic [QW-1:0]     qbase_i,
  output logic              valid_o,
  output logic [QW-1:0]     qid_o
);
  logic [QW-1:0] qid_d;

  assign qid_d = qbase_i | (QW'(hash_i >> shift_i) & qmask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      qid_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) qid_o <= qid_d;
    end
  end

  AST_QID_KEEPS_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((qid_o ^ $past(qbase_i)) & ~$past(qmask_i)) == '0); // R7
endmodule

// File: rtl/hqd_dist.sv
module hqd_dist
  import hqd_pkg::*;
#(
  parameter int unsigned QW = 24,
  parameter int unsigned SW = 6,
  parameter int unsigned PW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scm_en_i,
  input  logic [NUM_FLD-1:0] scm_fld_sel_i,
  input  logic [1:0]         scm_ip_dsel_i,
  input  logic [1:0]         scm_l4_dsel_i,
  input  logic [FLD_W-1:0]   scm_dflt0_i,
  input  logic [FLD_W-1:0]   scm_dflt1_i,
  input  logic               scm_sym_i,
  input  logic [SW-1:0]      scm_shift_i,
  input  logic [QW-1:0]      scm_qmask_i,
  input  logic [QW-1:0]      scm_qbase_i,
  input  logic               frm_valid_i,
  input  logic               frm_ip_ok_i,
  input  logic               frm_l4_ok_i,
  input  logic [FLD_W-1:0]   frm_ip_src_i,
  input  logic [FLD_W-1:0]   frm_ip_dst_i,
  input  logic [FLD_W-1:0]   frm_spi_i,
  input  logic [PW-1:0]      frm_l4_src_i,
  input  logic [PW-1:0]      frm_l4_dst_i,
  output logic               qid_valid_o,
  output logic [QW-1:0]      qid_o
);
  logic                          k_valid;
  logic [NUM_FLD-1:0]            k_sel;
  logic [NUM_FLD-1:0][FLD_W-1:0] k_fld;
  logic [SW-1:0]                 k_shift, h_shift;
  logic [QW-1:0]                 k_qmask, k_qbase, h_qmask, h_qbase;
  logic                          h_valid;
  logic [HASH_W-1:0]             h_hash;

  hqd_key_build #(.QW(QW), .SW(SW), .PW(PW)) i_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (scm_en_i),
    .fld_sel_i   (scm_fld_sel_i),
    .ip_dsel_i   (scm_ip_dsel_i),
    .l4_dsel_i   (scm_l4_dsel_i),
    .dflt0_i     (scm_dflt0_i),
    .dflt1_i     (scm_dflt1_i),
    .sym_i       (scm_sym_i),
    .shift_i     (scm_shift_i),
    .qmask_i     (scm_qmask_i),
    .qbase_i     (scm_qbase_i),
    .frm_valid_i (frm_valid_i),
    .ip_ok_i     (frm_ip_ok_i),
    .l4_ok_i     (frm_l4_ok_i),
    .ip_src_i    (frm_ip_src_i),
    .ip_dst_i    (frm_ip_dst_i),
    .spi_i       (frm_spi_i),
    .l4_src_i    (frm_l4_src_i),
    .l4_dst_i    (frm_l4_dst_i),
    .key_valid_o (k_valid),
    .key_sel_o   (k_sel),
    .key_fld_o   (k_fld),
    .key_shift_o (k_shift),
    .key_qmask_o (k_qmask),
    .key_qbase_o (k_qbase)
  );

  hqd_crc_stage #(.QW(QW), .SW(SW)) i_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (k_valid),
    .sel_i   (k_sel),
    .fld_i   (k_fld),
    .shift_i (k_shift),
    .qmask_i (k_qmask),
    .qbase_i (k_qbase),
    .valid_o (h_valid),
    .hash_o  (h_hash),
    .shift_o (h_shift),
    .qmask_o (h_qmask),
    .qbase_o (h_qbase)
  );

  hqd_qsel #(.QW(QW), .SW(SW)) i_qsel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (h_valid),
    .hash_i  (h_hash),
    .shift_i (h_shift),
    .qmask_i (h_qmask),
    .qbase_i (h_qbase),
    .valid_o (qid_valid_o),
    .qid_o   (qid_o)
  );

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && scm_en_i |=> ##2 qid_valid_o); // R2
  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && !scm_en_i |=> ##2 !qid_valid_o); // R1
  AST_NO_IDLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> ##2 !qid_valid_o); // R2
endmodule

// File: tb/test_hqd_dist.sv
`timescale 1ns/1ps
module test_hqd_dist;
  localparam logic [63:0] POLY = 64'h42F0_E1EB_A9EA_3693;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        en, sym, fv, ipok, l4ok;
  logic [4:0]  fsel;
  logic [1:0]  ipc, l4c;
  logic [31:0] d0, d1, ips, ipd, spi;
  logic [5:0]  sh;
  logic [23:0] qm, qb;
  logic [15:0] l4s, l4d;
  logic        qv;
  logic [23:0] q;

  int n_chk = 0;
  int n_err = 0;

  hqd_dist i_hqd_dist (
    .clk_i(clk), .rst_ni(rst_n),
    .scm_en_i(en), .scm_fld_sel_i(fsel), .scm_ip_dsel_i(ipc), .scm_l4_dsel_i(l4c),
    .scm_dflt0_i(d0), .scm_dflt1_i(d1), .scm_sym_i(sym), .scm_shift_i(sh),
    .scm_qmask_i(qm), .scm_qbase_i(qb),
    .frm_valid_i(fv), .frm_ip_ok_i(ipok), .frm_l4_ok_i(l4ok),
    .frm_ip_src_i(ips), .frm_ip_dst_i(ipd), .frm_spi_i(spi),
    .frm_l4_src_i(l4s), .frm_l4_dst_i(l4d),
    .qid_valid_o(qv), .qid_o(q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [1:0] c);
    if (c == 2'd2) return d0;
    if (c == 2'd3) return d1;
    return 32'h0;
  endfunction

  function automatic logic [23:0] model();
    logic [31:0] a, b, t, x;
    logic [15:0] p, r, y;
    logic [159:0] kv;
    logic [63:0] c;
    int n;
    logic fb;
    a = ipok ? ips : pick(ipc);
    b = ipok ? ipd : pick(ipc);
    t = pick(l4c);
    p = l4ok ? l4s : t[15:0];
    r = l4ok ? l4d : t[15:0];
    if (sym && a > b) begin x = a; a = b; b = x; end
    if (sym && p > r) begin y = p; p = r; r = y; end
    kv = '0; n = 0;
    if (fsel[4]) begin kv = {kv[127:0], a};   n += 32; end
    if (fsel[3]) begin kv = {kv[127:0], b};   n += 32; end
    if (fsel[2]) begin kv = {kv[127:0], spi}; n += 32; end
    if (fsel[1]) begin kv = {kv[143:0], p};   n += 16; end
    if (fsel[0]) begin kv = {kv[143:0], r};   n += 16; end
    c = '0;
    for (int k = n - 1; k >= 0; k--) begin
      fb = c[63] ^ kv[k];
      c = c << 1;
      if (fb) c = c ^ POLY;
    end
    return qb | (24'(c >> sh) & qm);
  endfunction

  // called at a negedge; leaves at the negedge where the result is visible
  task automatic run_one(input string tag, output logic [23:0] got);
    logic [23:0] ex;
    ex = model();
    fv = 1'b1;
    @(negedge clk);
    fv = 1'b0;
    @(negedge clk);
    chk("R2 early strobe", 32'(qv), 32'd0);
    @(negedge clk);
    if (en) begin
      chk(tag, 32'(qv), 32'd1);
      chk(tag, 32'(q), 32'(ex));
    end else begin
      chk("R1", 32'(qv), 32'd0);
    end
    got = q;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [23:0] g0, g1;
    logic [23:0] bexp [6];
    en = 1'b1; sym = 1'b0; fv = 1'b0; ipok = 1'b1; l4ok = 1'b1;
    fsel = 5'b11111; ipc = 2'd2; l4c = 2'd3;
    d0 = 32'h0A0A_0A0A; d1 = 32'h0B0B_0B0B;
    ips = 32'hC0A8_0101; ipd = 32'h0A00_0001; spi = 32'h1234_5678;
    l4s = 16'hD431; l4d = 16'h0050;
    sh = 6'd0; qm = 24'h0000FF; qb = 24'h5A0400;
    repeat (3) @(negedge clk);
    chk("R2 reset valid", 32'(qv), 32'd0);
    chk("R2 reset qid", 32'(q), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R8 R6 R7: sweep of field masks and absent combinations
    for (int e = 0; e < 32; e++) begin
      for (int v = 0; v < 8; v++) begin
        fsel = 5'(e);
        ipok = v[0]; l4ok = v[1]; sym = v[2];
        ipc = 2'(e % 4); l4c = 2'((e + 1) % 4);
        sh = 6'((e * 7 + v) % 64);
        case (e % 4)
          0: qm = 24'h000000;
          1: qm = 24'h00000F;
          2: qm = 24'h0000FF;
          default: qm = 24'h0003FF;
        endcase
        ips = 32'hC0A8_0000 + 32'(e * 97 + v);
        ipd = 32'h0A00_0001 + 32'(e * 13);
        l4s = 16'hD000 + 16'(e);
        l4d = 16'h0050 + 16'(v);
        spi = 32'h9E37_79B9 ^ 32'(e << 8);
        if (!ipok)      run_one("R4", g0);
        else if (!l4ok) run_one("R5", g0);
        else if (sym)   run_one("R8", g0);
        else            run_one("R3", g0);
      end
    end

    // R8: swapped direction gives the same queue
    fsel = 5'b11011; ipok = 1'b1; l4ok = 1'b1; sym = 1'b1; sh = 6'd5; qm = 24'h0003FF;
    ips = 32'hC0A8_0A0B; ipd = 32'h0A00_0002; l4s = 16'hC350; l4d = 16'h01BB;
    run_one("R8", g0);
    ips = 32'h0A00_0002; ipd = 32'hC0A8_0A0B; l4s = 16'h01BB; l4d = 16'hC350;
    run_one("R8", g1);
    chk("R8 swap equal", 32'(g1), 32'(g0));

    // R6: every shift amount
    sym = 1'b0; qm = 24'hFFFFFF; qb = 24'h000000;
    for (int s = 0; s < 64; s++) begin
      sh = 6'(s);
      run_one("R6", g0);
    end

    // R7: several queue ranges
    sh = 6'd0;
    for (int m = 0; m < 11; m++) begin
      qm = 24'((1 << m) - 1);
      qb = 24'h800000 | 24'(m << 11);
      run_one("R7", g0);
    end

    // R9: empty key
    fsel = 5'b00000; qm = 24'h00FFFF; qb = 24'h3A0000;
    run_one("R9", g0);
    chk("R9 base only", 32'(g0), 32'h003A0000);

    // R1: scheme disabled
    en = 1'b0; fsel = 5'b11111;
    run_one("R1", g0);
    en = 1'b1;

    // R10 R2: back-to-back frames, config changed each cycle and scrambled in flight
    for (int t = 0; t < 9; t++) begin
      if (t >= 3) begin
        chk("R2 burst strobe", 32'(qv), 32'd1);
        chk("R10 burst qid", 32'(q), 32'(bexp[t-3]));
      end
      if (t < 6) begin
        fsel = 5'(5'b10011 ^ 5'(t)); ipok = t[0]; l4ok = t[1]; sym = t[2];
        ipc = 2'(t % 4); l4c = 2'(3 - t % 4);
        sh = 6'(t * 9); qm = 24'h00003F; qb = 24'h100000 + 24'(t << 6);
        ips = 32'hAC10_0000 + 32'(t); ipd = 32'h0A00_0000 + 32'(7 * t);
        bexp[t] = model();
        fv = 1'b1;
      end else begin
        fv = 1'b0;
        fsel = ~fsel; sym = ~sym; sh = ~sh; qm = 24'hFFFFFF; qb = 24'hABCDEF;
        d0 = ~d0; d1 = d1 ^ 32'h5555_5555; ipc = ~ipc; l4c = ~l4c;
      end
      @(negedge clk);
    end
    chk("R2 burst end", 32'(qv), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule